// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a watchdog for a processor subsystem. Software arms it by writing one control word that carries a start count, a command (start or stop) and a 7-bit key. While armed, an 8-bit counter counts down one step per prescaler period. The prescaler divides the system clock by 2^17, which gives roughly 763 Hz from a 100 MHz clock. Software keeps the system alive by sending start commands again before the count runs out. Each of these reloads the counter.

A stray or runaway write cannot keep the watchdog alive or silence it. A command takes effect only when its key is the bitwise complement of the key of the last accepted command. A write with any other key changes nothing, except that it sets a sticky error flag.

When the count falls from 2 to 1, the block sends a one-cycle pulse toward the non-maskable interrupt input. This warns software one period before the end. When the count reaches 0, the block drives a chip-reset output for a fixed number of cycles and disarms itself.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous active-low reset, the block is disarmed. `count_o` is 0, `nmi_o`, `chip_rst_o` and `key_err_o` are low, and the stored key is 0x00, so the first valid key is 0x7F.
- R2: While armed, `count_o` falls by exactly one every 2^PRESC_W cycles. The first decrement lands exactly 2^PRESC_W cycles after the accepting clock edge.
- R3: When the count steps from 2 to 1, `nmi_o` is high for exactly one cycle, and in that cycle `count_o` reads 1.
- R4: When an armed count reaches 0, `chip_rst_o` rises in the same cycle that `count_o` reads 0, and the block disarms. This also covers a start with count 1 and a start with count 0. Both bite after one period, and neither gives an NMI.
- R5: A write whose key is not the complement of the stored key leaves the count, the armed state and the stored key unchanged. It also sets `key_err_o`, which stays high until reset.
- R6: `chip_rst_o` stays high for exactly RST_HOLD consecutive cycles.
- R7: A valid stop (`wr_cmd` = 0) halts the count, and `count_o` holds its value.
- R8: A valid start (`wr_cmd` = 1) loads `wr_count` into the counter and restarts the prescaler. A start sent while the counter is already running is a kick and cancels the pending NMI and reset.
- R9: Each accepted command stores its own key, so the next valid key is the complement of that key. Sending the same key twice is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_cmd | input | 1 | Command: 1 start/kick, 0 stop |
| wr_count | input | CNT_W | Start count for a start command |
| wr_key | input | KEY_W | Key; must be the complement of the last accepted key |
| count_o | output | CNT_W | Current counter value |
| nmi_o | output | 1 | One-cycle warning pulse on the 2-to-1 step |
| chip_rst_o | output | 1 | Chip reset, held RST_HOLD cycles |
| key_err_o | output | 1 | Sticky flag set by a rejected key |

## Verification
The hardest situation to reach from the ports is a rejected stop that arrives while the counter is counting down. Reaching it needs the key sequence tracked correctly across several earlier commands. The bench keeps its own model of the expected key and replays the key of the last accepted command. It then checks that the NMI and the reset still arrive on the cycles set by the earlier start. Kicks and stops are issued in the middle of a period, so that a cancelled countdown would show up as an event the scoreboard does not expect.

// File: rtl/wdt_pkg.sv
// Package: shared command encoding for the keyed watchdog.
// Assumes a one-bit command field in the control word.
package wdt_pkg;
    typedef enum logic {
        WDT_STOP  = 1'b0,
        WDT_START = 1'b1
    } wdt_cmd_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Free-running divider that yields one tick every 2^W cycles while enabled.
// Assumes restart has priority over counting; the tick is suppressed on restart.
module wdt_prescaler #(
    parameter int W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick_o
);
    logic [W-1:0] div_q;

    // Divider state: cleared on restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (run)     div_q <= div_q + 1'b1;
    end

    // Tick on the last state of the divide period.
    assign tick_o = run && !restart && (&div_q);
endmodule

// File: rtl/wdt_keygate.sv
// Key checker: accepts a write only if its key is the complement of the stored key.
// Assumes the stored key resets to KEY_INIT; rejected writes raise a sticky flag.
module wdt_keygate #(
    parameter int          KEY_W    = 7,
    parameter logic [KEY_W-1:0] KEY_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept_o,
    output logic             key_err_o
);
    logic [KEY_W-1:0] key_q;
    logic             err_q;

    assign accept_o  = wr_en && (wr_key == ~key_q);
    assign key_err_o = err_q;

    // Stored key follows each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)        key_q <= KEY_INIT;
        else if (accept_o) key_q <= wr_key;
    end

    // Sticky error: set by any rejected write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (wr_en && !accept_o) err_q <= 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
// Down-counter with warning and bite detection.
// Assumes load has priority over stop, and stop over a tick in the same cycle.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             halt,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             nmi_o,
    output logic             bite_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             nmi_q;
    logic             step;

    assign step      = tick && run_q && !load && !halt;
    assign bite_o    = step && (cnt_q <= ONE);
    assign count_o   = cnt_q;
    assign running_o = run_q;
    assign nmi_o     = nmi_q;

    // Count and armed state: load, halt, or one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (halt) begin
            run_q <= 1'b0;
        end else if (bite_o) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Warning pulse registered on the 2-to-1 step.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= step && (cnt_q == TWO);
    end
endmodule

// File: rtl/wdt_stretch.sv
// Pulse stretcher: holds its output for HOLD cycles after a fire pulse.
// Assumes HOLD >= 1; a new fire during the hold restarts the window.
module wdt_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic out_o
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left_q;

    // Remaining hold cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (fire)         left_q <= HW'(HOLD);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign out_o = (left_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
// Keyed countdown watchdog top: key gate, prescaler, counter, reset stretcher.
// Assumes one control write per wr_en cycle; a write overrides a tick in that cycle.
module keyed_wdt #(
    parameter int               CNT_W    = 8,
    parameter int               KEY_W    = 7,
    parameter int               PRESC_W  = 17,
    parameter int               RST_HOLD = 16,
    parameter logic [KEY_W-1:0] KEY_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [KEY_W-1:0] wr_key,
    output logic [CNT_W-1:0] count_o,
    output logic             nmi_o,
    output logic             chip_rst_o,
    output logic             key_err_o
);
    import wdt_pkg::*;

    logic accept;
    logic do_start;
    logic do_stop;
    logic tick;
    logic running;
    logic bite;

    assign do_start = accept && (wdt_cmd_e'(wr_cmd) == WDT_START);
    assign do_stop  = accept && (wdt_cmd_e'(wr_cmd) == WDT_STOP);

    wdt_keygate #(.KEY_W(KEY_W), .KEY_INIT(KEY_INIT)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
        .accept_o(accept), .key_err_o(key_err_o)
    );

    wdt_prescaler #(.W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(accept),
        .tick_o(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(do_start), .halt(do_stop),
        .load_val(wr_count), .tick(tick), .count_o(count_o),
        .running_o(running), .nmi_o(nmi_o), .bite_o(bite)
    );

    wdt_stretch #(.HOLD(RST_HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .fire(bite), .out_o(chip_rst_o)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
// Assertion checker for keyed_wdt, attached by bind below.
// Assumes synchronous active-low reset; all properties disabled during reset.
module keyed_wdt_chk #(
    parameter int CNT_W    = 8,
    parameter int RST_HOLD = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CNT_W-1:0] count_o,
    input logic             nmi_o,
    input logic             chip_rst_o,
    input logic             key_err_o
);
    logic [15:0] hi_len;

    // Length of the current high run of chip_rst_o.
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_len <= '0;
        else if (chip_rst_o) hi_len <= hi_len + 1'b1;
        else                 hi_len <= '0;
    end

    a_r3_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);
    a_r3_nmi_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (count_o == CNT_W'(1)));
    a_r4_rst_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_o) |-> (count_o == '0));
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_err_o |=> key_err_o);
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && count_o != '0) |=>
        (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
    a_r6_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst_o) |-> (32'(hi_len) == RST_HOLD));
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        32'(hi_len) <= RST_HOLD);
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .count_o(count_o),
    .nmi_o(nmi_o), .chip_rst_o(chip_rst_o), .key_err_o(key_err_o)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    localparam int PW   = 4;
    localparam int T    = 1 << PW;
    localparam int HOLD = 16;

    typedef struct { int kind; int cyc; } ev_t;   // kind 0 = NMI, 1 = reset

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic       wr_cmd = 0;
    logic [7:0] wr_count = 0;
    logic [6:0] wr_key = 0;
    logic [7:0] count_o;
    logic       nmi_o, chip_rst_o, key_err_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    ev_t  q[$];
    logic [6:0] stored_key = 7'h00;
    logic prev_rst = 0;
    int   rst_len = 0;

    keyed_wdt #(.PRESC_W(PW), .RST_HOLD(HOLD)) u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_count(wr_count), .wr_key(wr_key), .count_o(count_o),
        .nmi_o(nmi_o), .chip_rst_o(chip_rst_o), .key_err_o(key_err_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one control write; returns the cycle index after the accepting edge.
    task automatic write_cmd(input bit cmd, input int cnt, input logic [6:0] key, output int e);
        @(negedge clk);
        wr_en = 1; wr_cmd = cmd; wr_count = 8'(cnt); wr_key = key;
        @(posedge clk);
        @(negedge clk);
        e = cyc;
        wr_en = 0;
        if (key == ~stored_key) stored_key = key;
    endtask

    // Driver: push expected events for a countdown started at cycle e with count n.
    task automatic expect_run(input int e, input int n);
        ev_t v;
        if (n >= 2) begin v.kind = 0; v.cyc = e + T * (n - 1); q.push_back(v); end
        v.kind = 1; v.cyc = e + T * ((n == 0) ? 1 : n); q.push_back(v);
    endtask

    // Monitor: pop and compare events, measure reset length.
    always @(negedge clk) begin
        if (rst_n) begin
            if (nmi_o || (chip_rst_o && !prev_rst)) begin
                int k;
                k = nmi_o ? 0 : 1;
                if (q.size() == 0) begin
                    check(0, k ? "R4 unexpected reset" : "R3 unexpected NMI", cyc, -1);
                end else begin
                    ev_t v;
                    v = q.pop_front();
                    check(v.kind == k, "R3/R4 event kind", k, v.kind);
                    check(v.cyc == cyc, k ? "R4 reset cycle" : "R3 NMI cycle", cyc, v.cyc);
                end
            end
            if (chip_rst_o) rst_len++;
            else if (prev_rst) begin
                check(rst_len == HOLD, "R6 reset hold length", rst_len, HOLD);
                rst_len = 0;
            end
            prev_rst = chip_rst_o;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual %0d expected 0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e;
        int e2;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(count_o == 0, "R1 count", count_o, 0);
        check(nmi_o == 0 && chip_rst_o == 0, "R1 nmi/reset", {nmi_o, chip_rst_o}, 0);
        check(key_err_o == 0, "R1 key_err", key_err_o, 0);

        // R5 / R1: start with stored key 0x00 is rejected (valid key is 0x7F)
        write_cmd(1, 3, 7'h00, e);
        check(key_err_o == 1, "R5 key_err set", key_err_o, 1);
        wait_cyc(40);
        check(count_o == 0, "R5 rejected start ignored", count_o, 0);

        // R8/R2/R3/R4: valid start count 3
        write_cmd(1, 3, 7'h7F, e);
        expect_run(e, 3);
        check(count_o == 3, "R8 load", count_o, 3);
        wait_cyc(T - 1);
        check(count_o == 3, "R2 no early step", count_o, 3);
        wait_cyc(1);
        check(count_o == 2, "R2 first step", count_o, 2);
        wait_cyc(2 * T + HOLD + 4);
        check(q.size() == 0, "R4 events seen", q.size(), 0);
        wait_cyc(3 * T);
        check(count_o == 0, "R4 disarmed after bite", count_o, 0);
        check(key_err_o == 1, "R5 key_err sticky", key_err_o, 1);

        // R8 kick cancels pending countdown
        write_cmd(1, 5, 7'h00, e);
        wait_cyc(40);
        check(count_o == 3, "R2 mid-run count", count_o, 3);
        write_cmd(1, 5, 7'h7F, e2);
        expect_run(e2, 5);
        check(count_o == 5, "R8 kick reload", count_o, 5);
        wait_cyc(5 * T + HOLD + 4);
        check(q.size() == 0, "R8 kick events seen", q.size(), 0);

        // R7 valid stop holds count
        write_cmd(1, 4, 7'h00, e);
        wait_cyc(T + 4);
        write_cmd(0, 0, 7'h7F, e);
        check(count_o == 3, "R7 stop value", count_o, 3);
        wait_cyc(6 * T);
        check(count_o == 3, "R7 held after stop", count_o, 3);

        // R5/R9: rejected stop (repeated key) during run does not halt
        write_cmd(1, 3, 7'h00, e);
        expect_run(e, 3);
        wait_cyc(5);
        write_cmd(0, 0, 7'h00, e2);
        check(count_o == 3, "R5 rejected stop ignored", count_o, 3);
        wait_cyc(3 * T + HOLD + 4);
        check(q.size() == 0, "R5 run completed despite bad stop", q.size(), 0);

        // R9: stored key still 0x00, so 0x7F is accepted; count 1 gives no NMI (R4)
        write_cmd(1, 1, 7'h7F, e);
        check(count_o == 1, "R9 key kept after reject", count_o, 1);
        expect_run(e, 1);
        wait_cyc(T + HOLD + 4);
        check(q.size() == 0, "R4 count-1 bite", q.size(), 0);

        // R4: start with count 0 bites after one period
        write_cmd(1, 0, 7'h00, e);
        expect_run(e, 0);
        wait_cyc(T + HOLD + 4);
        check(q.size() == 0, "R4 count-0 bite", q.size(), 0);
        check(count_o == 0, "R4 count-0 final", count_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule